// File: doc/BRIEF.md
# Sticky Error Code Aggregator

This block gathers error pulses from a set of FIFO instances, from several internal state machines, from a cipher core and from a hardened counter into a single 32-bit status word. Software reads that word through a small register port. Each FIFO can signal three kinds of fault, and the block notes which kinds have occurred in three shared classification bits. The FIFO instance bits and the classification bits are kept separately.

Every recorded bit is sticky: only a reset clears it. While any bit is set, a fatal alert level is driven. A fatal interrupt request follows the alert when software has enabled it. A fault-injection register lets software raise a one-cycle pulse on any chosen bit position, so that the route to the alert and interrupt can be exercised without a real fault. A lock bit closes that register. The lock bit can be cleared but never set again.

Top module: `err_status_collector`

## Requirements
- R1: After reset the status word reads 0, the lock register (address 0, bit 0) reads 1, the interrupt enable (address 3, bit 0) reads 0, and `alert_o` and `intr_o` are low.
- R2: A pulse on `fifo_wfull_i[i]`, `fifo_rempty_i[i]` or `fifo_both_i[i]` sets status bit i (0 to 15). The bit is visible on the first read after the clock edge that samples the pulse.
- R3: A write-while-full pulse from any FIFO sets status bit 28, a read-while-empty pulse sets bit 29, and an empty-and-full pulse sets bit 30. Each of these is set on the same edge as the FIFO bit.
- R4: When several error inputs pulse in the same cycle, every corresponding bit is recorded.
- R5: `sm_err_i[j]` sets status bit 20+j, for j from 0 to 6. The order is command stage, main, generate, update-encrypt, update-output, cipher fatal, counter mismatch.
- R6: Once set, a status bit stays set until reset. A write to the status address (1) has no effect.
- R7: Status bits 16 to 19, 27 and 31 always read 0.
- R8: `alert_o` is high exactly when any status bit is set.
- R9: `intr_o` equals `alert_o` AND the interrupt enable bit, which is written at address 3, bit 0.
- R10: A write to address 2 while the lock bit is 1 injects a one-cycle pulse on status bit `wdata[4:0]`. An injection at a reserved position changes nothing.
- R11: Writing 0 to bit 0 of address 0 clears the lock bit, and writing 1 leaves it unchanged. While it is 0, writes to address 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_wfull_i | input | 16 | Per-FIFO write-while-full pulse |
| fifo_rempty_i | input | 16 | Per-FIFO read-while-empty pulse |
| fifo_both_i | input | 16 | Per-FIFO empty-and-full-together pulse |
| sm_err_i | input | 7 | State machine, cipher and counter fault pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the current address |
| alert_o | output | 1 | Fatal alert level |
| intr_o | output | 1 | Fatal interrupt request |

## Verification
A software injection and a hardware error pulse can arrive on the same clock edge. They may target the same bit or different bits, and both must be recorded. The bench drives an injection write in the same cycle as FIFO and state machine pulses. After that edge it compares the status word with the union of the two expected masks. It also starts from the pattern-table cases, where several FIFOs and error kinds fire together.

// File: rtl/errc_pkg.sv
package errc_pkg;
  localparam int unsigned StatusW  = 32;
  localparam int unsigned NumFifo  = 16;
  localparam int unsigned NumSm    = 7;
  localparam int unsigned SmBase   = 20;
  localparam int unsigned TypeBase = 28;
  localparam int unsigned InjW     = $clog2(StatusW);

  typedef enum logic [1:0] {
    AddrLock   = 2'd0,
    AddrStatus = 2'd1,
    AddrInject = 2'd2,
    AddrIntrEn = 2'd3
  } reg_addr_e;

  function automatic logic [StatusW-1:0] valid_mask();
    logic [StatusW-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NumFifo); i++) m[i] = 1'b1;
    for (int j = 0; j < int'(NumSm); j++) m[SmBase+j] = 1'b1;
    for (int k = 0; k < 3; k++) m[TypeBase+k] = 1'b1;
    return m;
  endfunction

  localparam logic [StatusW-1:0] ValidMask = valid_mask();
endpackage

// File: rtl/errc_sticky_bank.sv
module errc_sticky_bank
  import errc_pkg::*;
#(
  parameter int unsigned NFifo = NumFifo,
  parameter int unsigned NSm   = NumSm
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NFifo-1:0]   fifo_wfull_i,
  input  logic [NFifo-1:0]   fifo_rempty_i,
  input  logic [NFifo-1:0]   fifo_both_i,
  input  logic [NSm-1:0]     sm_err_i,
  input  logic [StatusW-1:0] inj_i,
  output logic [StatusW-1:0] status_o
);
  logic [StatusW-1:0] set_vec, status_d, status_q;
  logic               upd_en;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < int'(NFifo); i++)
      set_vec[i] = fifo_wfull_i[i] | fifo_rempty_i[i] | fifo_both_i[i];
    for (int j = 0; j < int'(NSm); j++)
      set_vec[SmBase+j] = sm_err_i[j];
    set_vec[TypeBase]   = |fifo_wfull_i;
    set_vec[TypeBase+1] = |fifo_rempty_i;
    set_vec[TypeBase+2] = |fifo_both_i;
    set_vec = set_vec | (inj_i & ValidMask);
  end

  assign upd_en   = |set_vec;
  assign status_d = status_q | set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     status_q <= '0;
    else if (upd_en) status_q <= status_d;
  end

  assign status_o = status_q;

  // R6: no bit ever falls once set
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R3: type bits follow any FIFO fault of that kind
  a_r3_type_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fifo_wfull_i) |=> status_q[TypeBase]);
  a_r3_type_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fifo_rempty_i) |=> status_q[TypeBase+1]);

  for (genvar g = 0; g < int'(NFifo); g++) begin : g_fifo_chk
    // R2: per-FIFO bit follows its pulse
    a_r2_fifo_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fifo_wfull_i[g] | fifo_rempty_i[g] | fifo_both_i[g]) |=> status_q[g]);
  end
endmodule

// File: rtl/errc_reg_port.sv
module errc_reg_port
  import errc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [StatusW-1:0] wdata_i,
  input  logic [StatusW-1:0] status_i,
  output logic [StatusW-1:0] rdata_o,
  output logic [StatusW-1:0] inj_o,
  output logic               intr_en_o
);
  logic lock_q, lock_d, lock_en;
  logic ien_q, ien_en;
  logic inj_wr;

  assign lock_en = we_i && (addr_i == AddrLock) && !wdata_i[0];
  assign lock_d  = 1'b0;
  assign ien_en  = we_i && (addr_i == AddrIntrEn);
  assign inj_wr  = we_i && (addr_i == AddrInject) && lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
      ien_q  <= 1'b0;
    end else begin
      if (lock_en) lock_q <= lock_d;
      if (ien_en)  ien_q  <= wdata_i[0];
    end
  end

  always_comb begin
    inj_o = '0;
    if (inj_wr) inj_o[wdata_i[InjW-1:0]] = 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AddrLock:   rdata_o[0] = lock_q;
      AddrStatus: rdata_o    = status_i;
      AddrIntrEn: rdata_o[0] = ien_q;
      default:    rdata_o    = '0;
    endcase
  end

  assign intr_en_o = ien_q;

  // R11: lock never returns to 1 without reset
  a_r11_lock_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q);
endmodule

// File: rtl/err_status_collector.sv
module err_status_collector
  import errc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] fifo_wfull_i,
  input  logic [15:0] fifo_rempty_i,
  input  logic [15:0] fifo_both_i,
  input  logic [6:0]  sm_err_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        alert_o,
  output logic        intr_o
);
  logic [StatusW-1:0] status, inj;
  logic               intr_en;

  errc_reg_port u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .status_i  (status),
    .rdata_o   (reg_rdata_o),
    .inj_o     (inj),
    .intr_en_o (intr_en)
  );

  errc_sticky_bank #(.NFifo(NumFifo), .NSm(NumSm)) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fifo_wfull_i  (fifo_wfull_i),
    .fifo_rempty_i (fifo_rempty_i),
    .fifo_both_i   (fifo_both_i),
    .sm_err_i      (sm_err_i),
    .inj_i         (inj),
    .status_o      (status)
  );

  assign alert_o = |status;
  assign intr_o  = alert_o & intr_en;

  // R5/R8: any state machine fault leads to the alert
  a_r5_sm_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sm_err_i) |=> alert_o);

  // R7: reserved positions read zero on the port
  a_r7_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == AddrStatus) |-> ((reg_rdata_o & ~ValidMask) == '0));

  // R9: interrupt never without alert
  a_r9_intr_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> alert_o);
endmodule

// File: tb/err_status_collector_tb_top.sv
module err_status_collector_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] fifo_wfull_i, fifo_rempty_i, fifo_both_i;
  logic [6:0]  sm_err_i;
  logic        reg_we_i;
  logic [1:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        alert_o, intr_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk_i = ~clk_i;

  err_status_collector dut_i (.*);

  // {wfull, rempty, both, sm, expected status}
  localparam int NV = 7;
  localparam logic [86:0] VEC [NV] = '{
    {16'h0001, 16'h0000, 16'h0000, 7'h00, 32'h1000_0001},
    {16'h0000, 16'h0020, 16'h0000, 7'h00, 32'h2000_0020},
    {16'h0000, 16'h0000, 16'h8000, 7'h00, 32'h4000_8000},
    {16'h0008, 16'h0008, 16'h0000, 7'h00, 32'h3000_0008},
    {16'h0000, 16'h0000, 16'h0000, 7'h01, 32'h0010_0000},
    {16'h0000, 16'h0000, 16'h0000, 7'h40, 32'h0400_0000},
    {16'hFFFF, 16'h0000, 16'h0000, 7'h7F, 32'h17F0_FFFF}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    fifo_wfull_i = '0; fifo_rempty_i = '0; fifo_both_i = '0; sm_err_i = '0;
    reg_we_i = 1'b0; reg_addr_i = 2'd1; reg_wdata_i = '0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = 2'd1;
  endtask

  function automatic logic [31:0] rd(logic [1:0] a);
    reg_addr_i = a;
    return reg_rdata_o;
  endfunction

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    reg_addr_i = a;
    #1;
    check(req, reg_rdata_o, exp);
    reg_addr_i = 2'd1;
  endtask

  initial begin
    rst_ni = 1'b0;
    do_reset();
    // R1 reset state
    rd_chk("R1 status", 2'd1, 32'h0);
    rd_chk("R1 lock", 2'd0, 32'h1);
    rd_chk("R1 intr_en", 2'd3, 32'h0);
    check("R1 alert", {31'b0, alert_o}, 32'h0);
    check("R1 intr", {31'b0, intr_o}, 32'h0);

    // R2 R3 R4 R5 pattern table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      {fifo_wfull_i, fifo_rempty_i, fifo_both_i, sm_err_i} = VEC[v][86:32];
      @(negedge clk_i);
      fifo_wfull_i = '0; fifo_rempty_i = '0; fifo_both_i = '0; sm_err_i = '0;
      rd_chk("R2/R3/R4/R5 table", 2'd1, VEC[v][31:0]);
      check("R8 alert after table", {31'b0, alert_o}, 32'h1);
    end

    // R6 sticky, status write ignored
    wr(2'd1, 32'h0);
    @(negedge clk_i);
    rd_chk("R6 sticky", 2'd1, 32'h17F0_FFFF);

    // R9 interrupt enable
    check("R9 intr off", {31'b0, intr_o}, 32'h0);
    wr(2'd3, 32'h1);
    check("R9 intr on", {31'b0, intr_o}, 32'h1);

    // R10 reserved injections have no effect; R7 reserved zero
    do_reset();
    wr(2'd2, 32'd16);
    wr(2'd2, 32'd27);
    wr(2'd2, 32'd31);
    wr(2'd2, 32'd19);
    rd_chk("R10/R7 reserved inject", 2'd1, 32'h0);
    check("R8 no alert", {31'b0, alert_o}, 32'h0);

    // R10 valid injections
    wr(2'd2, 32'd22);
    rd_chk("R10 inject 22", 2'd1, 32'h0040_0000);
    check("R8 alert after inject", {31'b0, alert_o}, 32'h1);
    wr(2'd2, 32'd29);
    rd_chk("R10 inject 29", 2'd1, 32'h2040_0000);

    // R4 injection coinciding with hardware pulses
    do_reset();
    fifo_both_i = 16'h0004; sm_err_i = 7'h10;
    reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 32'd7;
    @(negedge clk_i);
    reg_we_i = 1'b0; fifo_both_i = '0; sm_err_i = '0;
    rd_chk("R4 inject+hw same cycle", 2'd1, 32'h4100_0084);

    // R11 lock
    do_reset();
    wr(2'd0, 32'h0);
    rd_chk("R11 lock cleared", 2'd0, 32'h0);
    wr(2'd0, 32'h1);
    rd_chk("R11 lock stays clear", 2'd0, 32'h0);
    wr(2'd2, 32'd3);
    rd_chk("R11 inject ignored", 2'd1, 32'h0);
    check("R11 alert low", {31'b0, alert_o}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule